// File: doc/BRIEF.md
# Flash Read-Mode Command Interface

This block models the read side of a parallel NOR flash command interface. The host writes a command byte on the data bus with a write-enable pulse. The byte picks one of three read modes, and that mode stays in force until another recognised command arrives. In array mode a read returns the byte stored at the word address. In identifier mode a read returns fixed identification codes or per-block lock and erase-result bytes, chosen by the address. In status mode a read returns a status byte. That byte is frozen at the moment the read enables all become active.

The model samples its pins on a system clock. Two active-low chip enables, one output enable and one write enable are treated as levels that the host changes between clock edges. The storage array is a small register file that the host loads through a preload port. Per-block lock and erase-failure flags, and a busy flag, come in as inputs.

The mode state machine has three states: `MODE_ARRAY`, `MODE_IDENT` and `MODE_STATUS`. Each state moves on a captured command as follows:
- FFh leads to `MODE_ARRAY`.
- 90h leads to `MODE_IDENT`.
- 70h leads to `MODE_STATUS`.
- Any other byte is a self-loop that keeps the current state.

Top module: `flash_read_if`

## Requirements
- R1: After reset the block is in array mode, so a read of word address A returns the byte last preloaded at A.
- R2: A command is captured when WE# is sampled high after having been sampled low, while both chip enables are low. The captured byte sets the mode as follows: FFh selects array, 90h selects identifier, 70h selects status.
- R3: A captured byte other than FFh, 90h or 70h leaves the mode unchanged. A WE# pulse while either chip enable is high captures nothing.
- R4: The selected mode persists across any number of reads until a new recognised command is captured.
- R5: In identifier mode, word address 0 reads B0h.
- R6: In identifier mode, word address 1 reads D0h when parameter DENSITY_32M is 0 and D4h when it is 1.
- R7: In identifier mode, any other word address whose offset inside its block (the low BLK_SHIFT address bits) is 2 reads {6'b0, erase-fail, locked} for that block. The block index is the upper address bits. All other identifier addresses read 00h.
- R8: In status mode, a read returns {ready, 7'b0}, where ready = not busy.
- R9: The status byte is captured when CE0#, CE1# and OE# first become all low. It stays fixed while they remain low, even if busy changes. A new value appears only after one of them returns high and all go low again.
- R10: dq_oe is high only while CE0#, CE1# and OE# are low and WE# is high. Otherwise dq_oe is low.
- R11: With pre_we high at a clock edge, pre_data is stored at pre_addr in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce0_n | input | 1 | Chip enable 0, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq_i | input | 8 | Data bus, host to device |
| dq_o | output | 8 | Data bus, device to host |
| dq_oe | output | 1 | Device drives the data bus |
| busy | input | 1 | Internal operation in progress |
| blk_locked | input | NUM_BLK | Per-block lock flags |
| blk_efail | input | NUM_BLK | Per-block last-erase-failed flags |
| pre_we | input | 1 | Array preload strobe |
| pre_addr | input | ADDR_W | Array preload address |
| pre_data | input | 8 | Array preload byte |

## Verification
The bench changes busy while the enables stay low. A model that tracks busy live instead of freezing it would show the new ready bit without an enable toggle. Unrecognised command bytes and a WE# pulse with one chip enable high are both sent. A decoder that accepts any byte, or one that ignores the enables, would switch mode, and a following array read would then return an identifier or status value. Identifier reads cover offset 2 in several blocks and the neighbouring offsets, which catches a wrong block index or a missing address decode. The bench also holds OE# low while WE# is low, to catch a bus driver that ignores WE#.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY  = 2'd0,
        MODE_IDENT  = 2'd1,
        MODE_STATUS = 2'd2
    } rd_mode_e;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] ID_MFR        = 8'hB0;
    localparam logic [7:0] ID_DEV_16M    = 8'hD0;
    localparam logic [7:0] ID_DEV_32M    = 8'hD4;
endpackage

// File: rtl/flash_mode_fsm.sv
module flash_mode_fsm
    import flash_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_stb,
    input  logic [7:0] cmd_byte,
    output rd_mode_e   mode_o
);
    rd_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_ARRAY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cmd_stb) begin
            unique case (cmd_byte)
                CMD_RD_ARRAY:  state_d = MODE_ARRAY;
                CMD_RD_IDENT:  state_d = MODE_IDENT;
                CMD_RD_STATUS: state_d = MODE_STATUS;
                default:       state_d = state_q;
            endcase
        end
    end

    assign mode_o = state_q;

    // R3
    unknown_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_byte != CMD_RD_ARRAY && cmd_byte != CMD_RD_IDENT &&
         cmd_byte != CMD_RD_STATUS) |=> $stable(mode_o));

    // R4
    no_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_stb |=> $stable(mode_o));
endmodule

// File: rtl/flash_stat_snap.sv
module flash_stat_snap (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       all_low,
    input  logic [7:0] status_live,
    output logic [7:0] status_o
);
    logic       al_q;
    logic [7:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q   <= 1'b0;
            snap_q <= 8'h00;
        end else begin
            al_q <= all_low;
            if (all_low && !al_q) snap_q <= status_live;
        end
    end

    // the byte being latched shows in the cycle of the fall
    assign status_o = al_q ? snap_q : status_live;

    // R9
    snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (al_q && all_low) |=> $stable(status_o));
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BLK_SHIFT   = 4,
    parameter int NUM_BLK     = 16,
    parameter bit DENSITY_32M = 1'b0
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_BLK-1:0] blk_locked,
    input  logic [NUM_BLK-1:0] blk_efail,
    output logic [7:0]         id_o
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    logic [7:0]           dev_code;
    logic [BLK_SHIFT-1:0] offs;
    logic [BLK_W-1:0]     blk;

    generate
        if (DENSITY_32M) begin : g_dev32
            assign dev_code = ID_DEV_32M;
        end else begin : g_dev16
            assign dev_code = ID_DEV_16M;
        end
    endgenerate

    assign offs = addr[BLK_SHIFT-1:0];
    assign blk  = addr[ADDR_W-1:BLK_SHIFT];

    always_comb begin
        if (addr == '0)
            id_o = ID_MFR;
        else if (addr == ADDR_W'(1))
            id_o = dev_code;
        else if (offs == BLK_SHIFT'(2))
            id_o = {6'b0, blk_efail[blk], blk_locked[blk]};
        else
            id_o = 8'h00;
    end
endmodule

// File: rtl/flash_read_if.sv
module flash_read_if
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int BLK_SHIFT   = 4,
    parameter bit DENSITY_32M = 1'b0,
    localparam int NUM_BLK    = 1 << (ADDR_W - BLK_SHIFT),
    localparam int DEPTH      = 1 << ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce0_n,
    input  logic               ce1_n,
    input  logic               oe_n,
    input  logic               we_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         dq_i,
    output logic [7:0]         dq_o,
    output logic               dq_oe,
    input  logic               busy,
    input  logic [NUM_BLK-1:0] blk_locked,
    input  logic [NUM_BLK-1:0] blk_efail,
    input  logic               pre_we,
    input  logic [ADDR_W-1:0]  pre_addr,
    input  logic [7:0]         pre_data
);
    logic [7:0] mem [DEPTH];
    logic       we_q;
    logic       chip_en, all_low, cmd_stb;
    logic [7:0] id_byte, stat_byte;
    rd_mode_e   mode;

    assign chip_en = !ce0_n && !ce1_n;
    assign all_low = chip_en && !oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_n;
    end

    assign cmd_stb = we_n && !we_q && chip_en;

    always_ff @(posedge clk) begin
        if (pre_we) mem[pre_addr] <= pre_data;
    end

    flash_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_stb  (cmd_stb),
        .cmd_byte (dq_i),
        .mode_o   (mode)
    );

    flash_id_rom #(
        .ADDR_W      (ADDR_W),
        .BLK_SHIFT   (BLK_SHIFT),
        .NUM_BLK     (NUM_BLK),
        .DENSITY_32M (DENSITY_32M)
    ) u_id (
        .addr       (addr),
        .blk_locked (blk_locked),
        .blk_efail  (blk_efail),
        .id_o       (id_byte)
    );

    flash_stat_snap u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_low     (all_low),
        .status_live ({!busy, 7'b0}),
        .status_o    (stat_byte)
    );

    always_comb begin
        dq_oe = all_low && we_n;
        dq_o  = 8'h00;
        if (dq_oe) begin
            unique case (mode)
                MODE_ARRAY:  dq_o = mem[addr];
                MODE_IDENT:  dq_o = id_byte;
                MODE_STATUS: dq_o = stat_byte;
                default:     dq_o = 8'h00;
            endcase
        end
    end

    // R5
    id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDENT && dq_oe && addr == '0) |-> dq_o == 8'hB0);

    // R7
    id_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDENT && dq_oe) |-> dq_o[7:2] == 6'b0 || addr < ADDR_W'(2));

    // R9
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STATUS && $past(mode) == MODE_STATUS && dq_oe && $past(dq_oe))
        |-> $stable(dq_o));

    // R10
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || !we_n) |-> !dq_oe);
endmodule

// File: tb/flash_read_if_tb.sv
module flash_read_if_tb_top;
    localparam int ADDR_W    = 8;
    localparam int BLK_SHIFT = 4;
    localparam bit D32       = 1'b0;
    localparam int NUM_BLK   = 1 << (ADDR_W - BLK_SHIFT);

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce0_n = 1'b1, ce1_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0, pre_addr = '0;
    logic [7:0] dq_i = '0, pre_data = '0, dq_o;
    logic dq_oe, busy = 1'b0, pre_we = 1'b0;
    logic [NUM_BLK-1:0] blk_locked = '0, blk_efail = '0;

    int n_chk = 0, n_bad = 0;
    int exp_mode = 0;  // 0 array, 1 ident, 2 status
    logic [7:0] model_mem [1 << ADDR_W];

    always #2 clk = ~clk;

    flash_read_if #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .DENSITY_32M(D32)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce0_n(ce0_n), .ce1_n(ce1_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .busy(busy), .blk_locked(blk_locked), .blk_efail(blk_efail),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data));

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_ident(input logic [ADDR_W-1:0] a);
        if (a == 0) return 8'hB0;
        if (a == 1) return D32 ? 8'hD4 : 8'hD0;
        if (a[BLK_SHIFT-1:0] == 2)
            return {6'b0, blk_efail[a[ADDR_W-1:BLK_SHIFT]], blk_locked[a[ADDR_W-1:BLK_SHIFT]]};
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_read(input logic [ADDR_W-1:0] a);
        if (exp_mode == 1) return exp_ident(a);
        if (exp_mode == 2) return {~busy, 7'b0};
        return model_mem[a];
    endfunction

    task automatic write_cmd(input logic [7:0] c, input bit en);
        @(negedge clk);
        ce0_n = 1'b0; ce1_n = !en; we_n = 1'b0; dq_i = c;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce0_n = 1'b1; ce1_n = 1'b1;
        if (en) begin
            if (c == 8'hFF) exp_mode = 0;
            else if (c == 8'h90) exp_mode = 1;
            else if (c == 8'h70) exp_mode = 2;
        end
    endtask

    task automatic read_at(input logic [ADDR_W-1:0] a, output logic [7:0] v, output logic oe);
        @(negedge clk);
        addr = a; ce0_n = 1'b0; ce1_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        v = dq_o; oe = dq_oe;
        ce0_n = 1'b1; ce1_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic oe;
        int seed;
        seed = 17;
        v = $urandom(seed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: preload the array
        for (int i = 0; i < (1 << ADDR_W); i++) begin
            @(negedge clk);
            pre_we = 1'b1; pre_addr = ADDR_W'(i); pre_data = 8'($urandom);
            model_mem[i] = pre_data;
        end
        @(negedge clk); pre_we = 1'b0;
        // R10 idle bus
        check("R10 idle oe", {7'b0, dq_oe}, 8'h00);
        // R1 reset mode is array
        read_at(8'h05, v, oe);
        check("R1 array after reset", v, model_mem[5]);
        check("R10 oe during read", {7'b0, oe}, 8'h01);
        // R10 WE low with OE low: not driven
        @(negedge clk); ce0_n = 0; ce1_n = 0; oe_n = 0; we_n = 0; dq_i = 8'h00;
        @(negedge clk); check("R10 we low", {7'b0, dq_oe}, 8'h00);
        oe_n = 1; @(negedge clk); we_n = 1; @(negedge clk); ce0_n = 1; ce1_n = 1;
        // R3 disabled pulse and unknown byte
        write_cmd(8'h90, 1'b0);
        read_at(8'h02, v, oe);
        check("R3 disabled we ignored", v, model_mem[2]);
        write_cmd(8'h55, 1'b1);
        read_at(8'h11, v, oe);
        check("R3 unknown cmd ignored", v, model_mem[8'h11]);
        // R2/R5/R6/R7 identifier
        blk_locked = 16'h0005; blk_efail = 16'h0006;
        write_cmd(8'h90, 1'b1);
        read_at(8'h00, v, oe); check("R5 mfr code", v, 8'hB0);
        read_at(8'h01, v, oe); check("R6 dev code", v, 8'hD0);
        read_at(8'h02, v, oe); check("R7 blk0", v, 8'h01);
        read_at(8'h12, v, oe); check("R7 blk1", v, 8'h02);
        read_at(8'h22, v, oe); check("R7 blk2", v, 8'h03);
        read_at(8'h13, v, oe); check("R7 off3", v, 8'h00);
        write_cmd(8'hA5, 1'b1);
        read_at(8'h00, v, oe); check("R4 ident persists", v, 8'hB0);
        // R8/R9 status snapshot
        write_cmd(8'h70, 1'b1);
        busy = 1'b0;
        @(negedge clk); addr = 8'h33; ce0_n = 0; ce1_n = 0; oe_n = 0;
        @(negedge clk); check("R8 ready", dq_o, 8'h80);
        busy = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 frozen while held", dq_o, 8'h80);
        oe_n = 1'b1; @(negedge clk); oe_n = 1'b0;
        @(negedge clk); check("R9 refresh after toggle", dq_o, 8'h00);
        ce0_n = 1; ce1_n = 1; oe_n = 1;
        // mixed random traffic
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op == 0) write_cmd(8'hFF, 1'b1);
            else if (op == 1) write_cmd(8'h90, 1'b1);
            else if (op == 2) write_cmd(8'h70, 1'b1);
            else if (op == 3) write_cmd(8'($urandom), $urandom_range(0, 1) == 1);
            else begin
                logic [ADDR_W-1:0] a;
                busy = $urandom_range(0, 1) == 1;
                blk_locked = NUM_BLK'($urandom);
                blk_efail = NUM_BLK'($urandom);
                a = ADDR_W'($urandom);
                if ($urandom_range(0, 1) == 1) a[BLK_SHIFT-1:0] = BLK_SHIFT'(2);
                read_at(a, v, oe);
                check("R2/R4 random read", v, exp_read(a));
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule